// File: doc/BRIEF.md
# Whole-Method Instruction Cache

This block is an instruction store for a stack-oriented core. It keeps one complete method at a time, never a fragment. Whenever the core calls a method, or returns into a caller, it presents the method's word address in main memory and its length in words. If that address matches the method already held, nothing happens. Otherwise the block raises a stall and copies the whole method, one word after another, through a simple single-outstanding memory read port.

Once the method is resident, the core fetches bytes with a program counter counted from the start of the method. That counter indexes the storage directly. Tags are compared only at call or return time, so the fetch path needs no tag lookup and no address translation. A method that is empty, or larger than the storage, is rejected with a one-cycle flag and leaves the resident method untouched.

Top module: `method_icache`

## Requirements
- R1: After reset, busy, memRdEn and lenError are low and no method is resident, so the first valid request always causes a fill.
- R2: A valid request (callValid high while idle, length 1..CACHE_WORDS) whose base differs from the resident method raises busy from the next cycle. Busy falls at the clock edge where the final word's memRdValid is sampled, after exactly length words have arrived.
- R3: A fill reads the memory addresses base, base+1, ..., base+length-1 in that order. At most one read is outstanding, and each memRdEn pulse lasts one cycle.
- R4: A valid request whose base equals the resident method's base is a hit: busy stays low and no memory read is issued.
- R5: fetchPc is a byte address relative to the method start. After the next clock edge, fetchByte holds byte fetchPc[1:0] of cached word fetchPc[PC_W-1:2], where byte 0 is bits 7:0 of the word. Cached word i is memory word base+i.
- R6: A request with length 0 or length above CACHE_WORDS sets lenError high for exactly the one cycle after the request, starts no fill and keeps the resident method, which still hits.
- R7: callValid is ignored while busy is high: the fill in progress completes with its original base and length.
- R8: A method of exactly CACHE_WORDS words fills the whole storage, and its last byte (fetchPc = 4*CACHE_WORDS-1) is returned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callValid | input | 1 | Call or return request strobe |
| callBase | input | ADDR_W | Method start word address in main memory |
| callLen | input | LEN_W | Method length in 32-bit words |
| busy | output | 1 | Fill in progress; the core stalls |
| lenError | output | 1 | One-cycle pulse: the request length was rejected |
| memRdEn | output | 1 | Memory read request (one-cycle pulse) |
| memRdAddr | output | ADDR_W | Memory word address of the read |
| memRdData | input | 32 | Returned memory word |
| memRdValid | input | 1 | memRdData is valid this cycle |
| fetchPc | input | PC_W | Method-relative byte program counter |
| fetchByte | output | 8 | Instruction byte for the previous cycle's fetchPc |

## Verification
On every cycle, the assertions check the control behaviour. A hit never raises busy, and a miss always does. Busy only ends on an arriving word. A request during a fill never ends it. Memory reads never overlap, and the fill never writes past the stated length. The orderly address sequence, the word count per fill, the byte placement of fetched data (including the last byte of a full-size method), and the survival of the resident method across rejected requests can only be shown by the bench's scenarios, which compare against a scoreboard of expected reads and a model of memory contents.

// File: rtl/mcache_pkg.sv
package mcache_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic captureReq;  // latch base/length, clear counter, invalidate tag
    logic wordWr;      // write arriving memory word, advance counter
    logic commitTag;   // mark the loaded method resident
  } dpCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fillState_t;

endpackage

// File: rtl/mcache_dp.sv
module mcache_dp
  import mcache_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CACHE_WORDS = 256,
  parameter int LEN_W       = 9,
  parameter int PC_W        = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] callBase,
  input  logic [LEN_W-1:0]  callLen,
  input  logic [31:0]       memRdData,
  input  logic [PC_W-1:0]   fetchPc,
  output logic              tagHit,
  output logic              lastWord,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [7:0]        fetchByte
);

  localparam int IDX_W = $clog2(CACHE_WORDS);

  logic [ADDR_W-1:0] reqBaseR;
  logic [LEN_W-1:0]  reqLenR;
  logic [LEN_W-1:0]  wordCnt;
  logic [ADDR_W-1:0] tagR;
  logic              tagValid;
  logic [31:0]       storeMem [CACHE_WORDS];
  logic [31:0]       rdWord;
  logic [1:0]        rdSel;

  // Request capture and fill counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBaseR <= '0;
      reqLenR  <= '0;
      wordCnt  <= '0;
    end else if (ctrl.captureReq) begin
      reqBaseR <= callBase;
      reqLenR  <= callLen;
      wordCnt  <= '0;
    end else if (ctrl.wordWr) begin
      wordCnt  <= wordCnt + LEN_W'(1);
    end
  end

  assign memRdAddr = reqBaseR + ADDR_W'(wordCnt);
  assign lastWord  = (wordCnt == reqLenR - LEN_W'(1));

  // Single tag for the resident method
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagR     <= '0;
      tagValid <= 1'b0;
    end else if (ctrl.captureReq) begin
      tagValid <= 1'b0;
    end else if (ctrl.commitTag) begin
      tagR     <= reqBaseR;
      tagValid <= 1'b1;
    end
  end

  assign tagHit = tagValid && (tagR == callBase);

  // Storage: written by fill, read by method-relative fetch
  always_ff @(posedge clk) begin
    if (ctrl.wordWr) storeMem[wordCnt[IDX_W-1:0]] <= memRdData;
  end

  always_ff @(posedge clk) begin
    rdWord <= storeMem[fetchPc[PC_W-1:2]];
    rdSel  <= fetchPc[1:0];
  end

  always_comb begin
    case (rdSel)
      2'd0:    fetchByte = rdWord[7:0];
      2'd1:    fetchByte = rdWord[15:8];
      2'd2:    fetchByte = rdWord[23:16];
      default: fetchByte = rdWord[31:24];
    endcase
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wordWr |-> (wordCnt < reqLenR)); // R3

endmodule

// File: rtl/mcache_ctrl.sv
module mcache_ctrl
  import mcache_pkg::*;
#(
  parameter int CACHE_WORDS = 256,
  parameter int LEN_W       = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             callValid,
  input  logic [LEN_W-1:0] callLen,
  input  logic             tagHit,
  input  logic             lastWord,
  input  logic             memRdValid,
  output dpCtrl_t          ctrl,
  output logic             busy,
  output logic             memRdEn,
  output logic             lenError
);

  fillState_t state, nextState;
  logic pending;
  logic lenOk;
  logic lenErrR;

  assign lenOk = (callLen != '0) && (callLen <= LEN_W'(CACHE_WORDS));

  always_comb begin
    ctrl      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (callValid && lenOk && !tagHit) begin
          ctrl.captureReq = 1'b1;
          nextState       = ST_FILL;
        end
      end
      default: begin
        if (memRdValid) begin
          ctrl.wordWr = 1'b1;
          if (lastWord) begin
            ctrl.commitTag = 1'b1;
            nextState      = ST_IDLE;
          end
        end
      end
    endcase
  end

  assign busy    = (state == ST_FILL);
  assign memRdEn = (state == ST_FILL) && !pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      lenErrR <= 1'b0;
    end else begin
      state   <= nextState;
      lenErrR <= (state == ST_IDLE) && callValid && !lenOk;
      if (ctrl.captureReq)  pending <= 1'b0;
      else if (memRdEn)     pending <= 1'b1;
      else if (memRdValid)  pending <= 1'b0;
    end
  end

  assign lenError = lenErrR;

  AST_MISS_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && callValid && lenOk && !tagHit) |=> busy); // R2
  AST_FILL_ENDS_ON_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(memRdValid)); // R2
  AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && callValid && tagHit) |=> !busy); // R4
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn); // R3
  AST_ERR_NO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    lenError |-> !busy); // R6
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (busy && callValid && !memRdValid) |=> busy); // R7

endmodule

// File: rtl/method_icache.sv
module method_icache
  import mcache_pkg::*;
#(
  parameter  int ADDR_W      = 24,
  parameter  int CACHE_WORDS = 256,
  localparam int LEN_W       = $clog2(CACHE_WORDS) + 1,
  localparam int PC_W        = $clog2(CACHE_WORDS) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callValid,
  input  logic [ADDR_W-1:0] callBase,
  input  logic [LEN_W-1:0]  callLen,
  output logic              busy,
  output logic              lenError,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  input  logic              memRdValid,
  input  logic [PC_W-1:0]   fetchPc,
  output logic [7:0]        fetchByte
);

  dpCtrl_t dpCtrl;
  logic    tagHit;
  logic    lastWord;

  mcache_ctrl #(
    .CACHE_WORDS(CACHE_WORDS),
    .LEN_W      (LEN_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .callValid (callValid),
    .callLen   (callLen),
    .tagHit    (tagHit),
    .lastWord  (lastWord),
    .memRdValid(memRdValid),
    .ctrl      (dpCtrl),
    .busy      (busy),
    .memRdEn   (memRdEn),
    .lenError  (lenError)
  );

  mcache_dp #(
    .ADDR_W     (ADDR_W),
    .CACHE_WORDS(CACHE_WORDS),
    .LEN_W      (LEN_W),
    .PC_W       (PC_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (dpCtrl),
    .callBase (callBase),
    .callLen  (callLen),
    .memRdData(memRdData),
    .fetchPc  (fetchPc),
    .tagHit   (tagHit),
    .lastWord (lastWord),
    .memRdAddr(memRdAddr),
    .fetchByte(fetchByte)
  );

endmodule

// File: tb/method_icache_tb_top.sv
module method_icache_tb_top;

  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 24;
  localparam int CACHE_WORDS = 256;
  localparam int LEN_W       = $clog2(CACHE_WORDS) + 1;
  localparam int PC_W        = $clog2(CACHE_WORDS) + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              callValid = 1'b0;
  logic [ADDR_W-1:0] callBase = '0;
  logic [LEN_W-1:0]  callLen = '0;
  logic              busy, lenError, memRdEn;
  logic [ADDR_W-1:0] memRdAddr;
  logic [31:0]       memRdData;
  logic              memRdValid;
  logic [PC_W-1:0]   fetchPc = '0;
  logic [7:0]        fetchByte;

  int checks = 0;
  int errors = 0;
  int delivered = 0;
  int memLat = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] expAddrQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  method_icache #(.ADDR_W(ADDR_W), .CACHE_WORDS(CACHE_WORDS)) dut_i (
    .clk(clk), .rstN(rstN), .callValid(callValid), .callBase(callBase),
    .callLen(callLen), .busy(busy), .lenError(lenError), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memRdValid(memRdValid),
    .fetchPc(fetchPc), .fetchByte(fetchByte)
  );

  function automatic logic [31:0] memWord(input logic [ADDR_W-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8], a[7:0] + 8'd1, a[15:8] ^ 8'hC3};
  endfunction

  // Memory model: one read at a time, memLat extra cycles
  logic              memPend;
  logic [ADDR_W-1:0] memAddrM;
  int                memCnt;
  always @(posedge clk) begin
    if (!rstN) begin
      memPend    <= 1'b0;
      memRdValid <= 1'b0;
      memRdData  <= '0;
    end else begin
      memRdValid <= 1'b0;
      if (memRdEn) begin
        memPend  <= 1'b1;
        memAddrM <= memRdAddr;
        memCnt   <= memLat;
      end else if (memPend) begin
        if (memCnt == 0) begin
          memRdValid <= 1'b1;
          memRdData  <= memWord(memAddrM);
          memPend    <= 1'b0;
        end else begin
          memCnt <= memCnt - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read addresses, counts delivered words
  always @(negedge clk) begin
    if (rstN && memRdEn) begin
      if (expAddrQ.size() == 0) begin
        chk(1'b0, "R4 unexpected memory read", longint'(memRdAddr), 0);
      end else begin
        logic [ADDR_W-1:0] e;
        e = expAddrQ.pop_front();
        chk(memRdAddr == e, "R3 read address order", longint'(memRdAddr), longint'(e));
      end
    end
    if (rstN && memRdValid) delivered++;
  end

  // Driver: one call/return request
  task automatic callMethod(input logic [ADDR_W-1:0] b, input int len,
                            input bit expMiss, input bit injectBusy, input int lat);
    memLat = lat;
    if (expMiss)
      for (int i = 0; i < len; i++) expAddrQ.push_back(b + ADDR_W'(i));
    @(negedge clk);
    delivered = 0;
    callValid = 1'b1;
    callBase  = b;
    callLen   = LEN_W'(len);
    @(negedge clk);
    callValid = 1'b0;
    chk(busy == expMiss, expMiss ? "R2 busy after miss" : "R4 no busy on hit",
        longint'(busy), longint'(expMiss));
    if (expMiss) begin
      for (int k = 0; busy && k < 5000; k++) begin
        if (injectBusy && k == 1) begin
          callValid = 1'b1;
          callBase  = b ^ ADDR_W'('h0F0);
          callLen   = LEN_W'(2);
        end else begin
          callValid = 1'b0;
        end
        @(negedge clk);
      end
      callValid = 1'b0;
      chk(delivered == len, injectBusy ? "R7 fill length kept" : "R2 words per fill",
          longint'(delivered), longint'(len));
      chk(expAddrQ.size() == 0, "R3 all reads issued", longint'(expAddrQ.size()), 0);
    end else begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R4 stays idle on hit", longint'(busy), 0);
    end
  endtask

  task automatic fetchCheck(input logic [ADDR_W-1:0] b, input int pc, input string req);
    logic [31:0] w;
    logic [7:0]  e;
    @(negedge clk);
    fetchPc = PC_W'(pc);
    @(negedge clk);
    w = memWord(b + ADDR_W'(pc / 4));
    e = w[8*(pc%4) +: 8];
    chk(fetchByte == e, req, longint'(fetchByte), longint'(e));
  endtask

  task automatic badLen(input int len);
    @(negedge clk);
    callValid = 1'b1;
    callBase  = 24'h00_7770;
    callLen   = LEN_W'(len);
    @(negedge clk);
    callValid = 1'b0;
    chk(lenError == 1'b1, "R6 lenError pulse", longint'(lenError), 1);
    chk(busy == 1'b0, "R6 no fill on bad length", longint'(busy), 0);
    @(negedge clk);
    chk(lenError == 1'b0, "R6 lenError one cycle", longint'(lenError), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && memRdEn == 1'b0 && lenError == 1'b0, "R1 reset outputs",
        longint'({busy, memRdEn, lenError}), 0);
    rstN = 1'b1;

    // R1/R2: first request misses; short method, no latency
    callMethod(24'h00_1000, 5, 1'b1, 1'b0, 0);
    for (int p = 0; p < 20; p += 3) fetchCheck(24'h00_1000, p, "R5 fetch byte");
    fetchCheck(24'h00_1000, 19, "R5 last byte of short method");

    // R4: same base hits
    callMethod(24'h00_1000, 5, 1'b0, 1'b0, 0);

    // R7: new method with latency, request injected while busy
    callMethod(24'h00_2040, 3, 1'b1, 1'b1, 3);
    fetchCheck(24'h00_2040, 6, "R7 contents of original fill");
    callMethod(24'h00_2040, 3, 1'b0, 1'b0, 0);

    // Return to the first method: miss again
    callMethod(24'h00_1000, 5, 1'b1, 1'b0, 1);

    // R6: rejected lengths keep the resident method
    badLen(0);
    badLen(CACHE_WORDS + 1);
    callMethod(24'h00_1000, 5, 1'b0, 1'b0, 0);
    fetchCheck(24'h00_1000, 9, "R6 resident data unchanged");

    // R8: full-size method
    callMethod(24'h00_0300, CACHE_WORDS, 1'b1, 1'b0, 0);
    fetchCheck(24'h00_0300, 4*CACHE_WORDS - 1, "R8 last byte full method");
    fetchCheck(24'h00_0300, 0, "R8 first byte full method");
    fetchCheck(24'h00_0300, 2*CACHE_WORDS + 2, "R8 middle byte full method");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule